// File: doc/BRIEF.md
# Channel Fault Guard for an Eight-Way Sink Driver

This block sits between the output data register of a serial-in, parallel-out low-side driver and its channel drivers. It decides, cycle by cycle, which channels may actually conduct. It takes the data word that the serial front end has latched, one overcurrent flag per channel and a single over-temperature flag. From these it produces the gated on-requests that go to the drivers. A channel that trips on overcurrent is forced off and held off. All held channels share one recovery timer, counted in system clocks. Every new trip restarts that timer for all channels that are held, so they are released together. While the over-temperature flag is up, every channel is off. Latch updates that arrive in that time are parked and applied when the flag drops.

All pins are plain level or pulse signals sampled on the rising clock edge. There is no streaming interface, so there is no back-pressure. The caller asserts the update pulse for one cycle with the new word on the data input. A synchronous clear, already filtered upstream, wipes the applied word, the parked word, all held faults and the timer.

Top module: `chan_fault_guard`

## Requirements
- R1: While a channel's gated output is 1, a 1 on its overcurrent flag at a rising edge sets its held bit at that edge. The channel's output is then 0 from that edge on, and the other channels are unchanged.
- R2: After the last trip edge, held channels stay off for exactly RECOV_CYCLES clock cycles. At the next edge all held bits clear together, and each channel returns to its applied value.
- R3: A trip on any channel while other channels are held restarts the shared interval for all of them.
- R4: An overcurrent flag has no effect on a channel whose gated output is 0. This covers a request bit of 0, a channel already held, or thermal shutdown.
- R5: If a released channel's flag is still 1 at release, the channel conducts for exactly one cycle and then trips again.
- R6: The thermal status output equals the over-temperature flag delayed by one cycle. While the status is 1, every gated output is 0.
- R7: An update pulse that arrives while the thermal status is 1 parks its word, and the latest such word wins. The parked word becomes the applied word at the edge where the status falls. An update pulse in that same cycle takes precedence over the parked word.
- R8: Outside thermal shutdown, an update pulse makes the data input the applied word one cycle later. A change of the data input without a pulse has no effect.
- R9: Clear at an edge zeroes the applied word, the parked word, all held bits and the timer. It takes precedence over an update pulse and over trips in the same cycle.
- R10: After reset, the gated outputs, the held mask and the thermal status are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Filtered synchronous clear, active high |
| upd_i | input | 1 | One-cycle pulse that loads the latched word |
| data_i | input | N_CH | Latched word, bit i requests channel i on |
| oc_flag_i | input | N_CH | Per-channel overcurrent flag |
| ot_flag_i | input | 1 | Over-temperature flag, hysteresis applied upstream |
| drive_on_o | output | N_CH | Gated on-request per channel |
| held_mask_o | output | N_CH | Channels currently held off by overcurrent |
| thermal_o | output | 1 | Thermal shutdown active |

## Verification
The hardest case to reach is a second trip that lands a few cycles before the shared timer runs out. It has to restart the release of an earlier channel. A retrip caused by a flag that is still high at release is nearly as hard. A directed sequence places the second trip a fixed number of cycles after the first. It then holds one flag across the release edge with the bench's recovery interval shortened to 12 cycles. A long random phase then applies sparse overcurrent, thermal and clear events on top of random updates, so trips overlap in varied ways.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

  typedef enum logic [1:0] {
    UPD_NONE    = 2'd0,
    UPD_APPLY   = 2'd1,
    UPD_DEFER   = 2'd2,
    UPD_RELEASE = 2'd3
  } cfg_upd_e;

  function automatic int unsigned cnt_width(input int unsigned span);
    return (span > 1) ? $clog2(span) : 1;
  endfunction

endpackage

// File: rtl/cfg_data_stage.sv
module cfg_data_stage
  import cfg_pkg::*;
#(
  parameter int unsigned N_CH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_i,
  input  logic            upd_i,
  input  logic [N_CH-1:0] data_i,
  input  logic            ot_i,
  output logic [N_CH-1:0] applied_o,
  output logic            thermal_o
);

  logic [N_CH-1:0] applied_q;
  logic [N_CH-1:0] parked_q;
  logic            parked_vld_q;
  logic            thermal_q;
  cfg_upd_e        act;

  always_comb begin
    if (thermal_q && !ot_i)  act = UPD_RELEASE;
    else if (upd_i)          act = thermal_q ? UPD_DEFER : UPD_APPLY;
    else                     act = UPD_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      applied_q    <= '0;
      parked_q     <= '0;
      parked_vld_q <= 1'b0;
      thermal_q    <= 1'b0;
    end else begin
      thermal_q <= ot_i;
      if (clr_i) begin
        applied_q    <= '0;
        parked_q     <= '0;
        parked_vld_q <= 1'b0;
      end else begin
        unique case (act)
          UPD_APPLY: applied_q <= data_i;
          UPD_DEFER: begin
            parked_q     <= data_i;
            parked_vld_q <= 1'b1;
          end
          UPD_RELEASE: begin
            if (upd_i)             applied_q <= data_i;
            else if (parked_vld_q) applied_q <= parked_q;
            parked_vld_q <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  assign applied_o = applied_q;
  assign thermal_o = thermal_q;

endmodule

// File: rtl/cfg_recovery_timer.sv
module cfg_recovery_timer
  import cfg_pkg::*;
#(
  parameter int unsigned RECOV_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic restart_i,
  input  logic run_i,
  output logic expire_o
);

  localparam int unsigned TW = cnt_width(RECOV_CYCLES);
  localparam logic [TW-1:0] LOAD = TW'(RECOV_CYCLES - 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (clr_i)                cnt_q <= '0;
    else if (restart_i)            cnt_q <= LOAD;
    else if (run_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expire_o = run_i && !restart_i && (cnt_q == '0);

endmodule

// File: rtl/cfg_trip_tracker.sv
module cfg_trip_tracker #(
  parameter int unsigned N_CH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_i,
  input  logic [N_CH-1:0] trip_i,
  input  logic            expire_i,
  output logic [N_CH-1:0] held_o,
  output logic            any_trip_o,
  output logic            any_held_o
);

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic held_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         held_q <= 1'b0;
      else if (clr_i)     held_q <= 1'b0;
      else if (trip_i[g]) held_q <= 1'b1;
      else if (expire_i)  held_q <= 1'b0;
    end
    assign held_o[g] = held_q;
  end

  assign any_trip_o = |trip_i;
  assign any_held_o = |held_o;

endmodule

// File: rtl/chan_fault_guard.sv
module chan_fault_guard #(
  parameter int unsigned N_CH         = 8,
  parameter int unsigned RECOV_CYCLES = 1000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_i,
  input  logic            upd_i,
  input  logic [N_CH-1:0] data_i,
  input  logic [N_CH-1:0] oc_flag_i,
  input  logic            ot_flag_i,
  output logic [N_CH-1:0] drive_on_o,
  output logic [N_CH-1:0] held_mask_o,
  output logic            thermal_o
);

  logic [N_CH-1:0] applied;
  logic [N_CH-1:0] held;
  logic [N_CH-1:0] trip;
  logic            thermal;
  logic            any_trip;
  logic            any_held;
  logic            expire;

  cfg_data_stage #(.N_CH(N_CH)) data_i0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (clr_i),
    .upd_i     (upd_i),
    .data_i    (data_i),
    .ot_i      (ot_flag_i),
    .applied_o (applied),
    .thermal_o (thermal)
  );

  cfg_trip_tracker #(.N_CH(N_CH)) trk_i0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (clr_i),
    .trip_i     (trip),
    .expire_i   (expire),
    .held_o     (held),
    .any_trip_o (any_trip),
    .any_held_o (any_held)
  );

  cfg_recovery_timer #(.RECOV_CYCLES(RECOV_CYCLES)) tmr_i0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (clr_i),
    .restart_i (any_trip),
    .run_i     (any_held),
    .expire_o  (expire)
  );

  assign drive_on_o  = applied & ~held & {N_CH{~thermal}};
  assign trip        = oc_flag_i & drive_on_o;
  assign held_mask_o = held;
  assign thermal_o   = thermal;

endmodule

// File: rtl/chan_fault_guard_chk.sv
module chan_fault_guard_chk #(
  parameter int unsigned N_CH         = 8,
  parameter int unsigned RECOV_CYCLES = 1000
) (
  input logic            clk,
  input logic            rst_n,
  input logic            clr_i,
  input logic [N_CH-1:0] oc_flag_i,
  input logic            ot_flag_i,
  input logic [N_CH-1:0] drive_on_o,
  input logic [N_CH-1:0] held_mask_o,
  input logic            thermal_o
);

  localparam int unsigned CW = $clog2(RECOV_CYCLES + 2) + 1;
  logic [CW-1:0] since_trip;
  logic          started;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_trip <= '0;
      started    <= 1'b0;
    end else begin
      started <= 1'b1;
      if (clr_i || |(oc_flag_i & drive_on_o)) since_trip <= '0;
      else if (|held_mask_o)                   since_trip <= since_trip + 1'b1;
      else                                     since_trip <= '0;
    end
  end

  a_r1_trip_sets_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && |(oc_flag_i & drive_on_o)) |=> (($past(oc_flag_i & drive_on_o) & ~held_mask_o) == '0));

  a_r2_held_is_off: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_on_o & held_mask_o) == '0);

  a_r2_hold_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (|held_mask_o) |-> (since_trip < CW'(RECOV_CYCLES)));

  a_r6_thermal_off: assert property (@(posedge clk) disable iff (!rst_n)
    thermal_o |-> (drive_on_o == '0));

  a_r6_thermal_follow: assert property (@(posedge clk) disable iff (!rst_n)
    started |=> (thermal_o == $past(ot_flag_i)));

  a_r9_clear_wipes: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (held_mask_o == '0 && drive_on_o == '0));

endmodule

bind chan_fault_guard chan_fault_guard_chk #(
  .N_CH(N_CH),
  .RECOV_CYCLES(RECOV_CYCLES)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .clr_i       (clr_i),
  .oc_flag_i   (oc_flag_i),
  .ot_flag_i   (ot_flag_i),
  .drive_on_o  (drive_on_o),
  .held_mask_o (held_mask_o),
  .thermal_o   (thermal_o)
);

// File: tb/chan_fault_guard_tb_top.sv
module chan_fault_guard_tb_top;

  localparam int N  = 8;
  localparam int RC = 12;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         clr_i = 1'b0;
  logic         upd_i = 1'b0;
  logic [N-1:0] data_i = '0;
  logic [N-1:0] oc_flag_i = '0;
  logic         ot_flag_i = 1'b0;
  logic [N-1:0] drive_on_o;
  logic [N-1:0] held_mask_o;
  logic         thermal_o;

  chan_fault_guard #(.N_CH(N), .RECOV_CYCLES(RC)) dut_i (.*);

  always #4 clk = ~clk;

  int    n_vec  = 0;
  int    n_bad  = 0;
  bit    done   = 0;
  string tag    = "R10";

  // bench expectation state
  logic [N-1:0] m_app, m_pq, m_held;
  logic         m_pend, m_th;
  int           m_tmr;

  function automatic logic [N-1:0] exp_drive();
    return m_app & ~m_held & {N{~m_th}};
  endfunction

  task automatic model_edge();
    logic [N-1:0] trip;
    trip = oc_flag_i & exp_drive();
    if (clr_i) begin
      m_app = '0; m_pq = '0; m_pend = 0; m_held = '0; m_tmr = 0;
    end else begin
      if (trip != '0) begin
        m_held = m_held | trip; m_tmr = RC - 1;
      end else if (m_held != '0) begin
        if (m_tmr == 0) m_held = '0; else m_tmr--;
      end
      if (m_th && !ot_flag_i) begin
        if (upd_i) m_app = data_i; else if (m_pend) m_app = m_pq;
        m_pend = 0;
      end else if (upd_i) begin
        if (m_th) begin m_pq = data_i; m_pend = 1; end
        else m_app = data_i;
      end
    end
    m_th = ot_flag_i;
  endtask

  task automatic compare();
    n_vec++;
    if (drive_on_o !== exp_drive() || held_mask_o !== m_held || thermal_o !== m_th) begin
      n_bad++;
      $display("FAIL %s: drive=%h held=%h th=%b expected drive=%h held=%h th=%b",
               tag, drive_on_o, held_mask_o, thermal_o, exp_drive(), m_held, m_th);
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
    upd_i = 0;
    clr_i = 0;
  endtask

  task automatic expect_bits(input string t, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", t, act, exp);
    end
  endtask

  initial begin
    #1600000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4829));
    m_app = '0; m_pq = '0; m_held = '0; m_pend = 0; m_th = 0; m_tmr = 0;
    repeat (3) @(negedge clk);
    tag = "R10"; compare();
    rst_n = 1;
    step();

    // R8: apply on pulse, ignore data change without pulse
    tag = "R8";
    data_i = 8'hA5; upd_i = 1; step();
    expect_bits("R8 apply", drive_on_o, 8'hA5);
    data_i = 8'h3C; step();
    expect_bits("R8 no pulse", drive_on_o, 8'hA5);

    // R1: trip channel 0
    tag = "R1";
    oc_flag_i = 8'h01; step();
    oc_flag_i = '0;
    expect_bits("R1 held", held_mask_o, 8'h01);
    expect_bits("R1 others", drive_on_o, 8'hA4);
    // R4: flag on an off channel (bit 1 requested 0) and on held channel 0
    tag = "R4";
    oc_flag_i = 8'h03; step(); oc_flag_i = '0;
    expect_bits("R4 ignored", held_mask_o, 8'h01);
    repeat (2) step();
    // R3: trip channel 2 restarts shared interval
    tag = "R3";
    oc_flag_i = 8'h04; step(); oc_flag_i = '0;
    expect_bits("R3 both held", held_mask_o, 8'h05);
    repeat (RC - 1) step();
    expect_bits("R3 still held", held_mask_o, 8'h05);
    tag = "R2"; step();
    expect_bits("R2 release together", held_mask_o, 8'h00);
    expect_bits("R2 drive back", drive_on_o, 8'hA5);

    // R5: flag held across release
    tag = "R5";
    oc_flag_i = 8'h80; step();
    expect_bits("R5 trip", held_mask_o, 8'h80);
    repeat (RC) step();
    expect_bits("R5 one cycle on", drive_on_o, 8'hA5);
    step();
    expect_bits("R5 retrip", drive_on_o, 8'h25);
    oc_flag_i = '0;
    repeat (RC + 2) step();

    // R6/R7: thermal shutdown with parked updates
    tag = "R6";
    ot_flag_i = 1; step();
    expect_bits("R6 all off", drive_on_o, 8'h00);
    tag = "R7";
    data_i = 8'h0F; upd_i = 1; step();
    data_i = 8'hF0; upd_i = 1; step();
    expect_bits("R7 still off", drive_on_o, 8'h00);
    ot_flag_i = 0; step();
    expect_bits("R7 latest parked", drive_on_o, 8'hF0);
    ot_flag_i = 1; step();
    ot_flag_i = 0; data_i = 8'h81; upd_i = 1; step();
    expect_bits("R7 pulse wins", drive_on_o, 8'h81);

    // R9: clear wins over update and trip
    tag = "R9";
    oc_flag_i = 8'h01; clr_i = 1; upd_i = 1; data_i = 8'hFF; step();
    oc_flag_i = '0;
    expect_bits("R9 cleared", drive_on_o | held_mask_o, 8'h00);

    // random phase
    tag = "R2 random";
    for (int i = 0; i < 4000; i++) begin
      upd_i     = ($urandom_range(0, 7) == 0);
      data_i    = N'($urandom);
      oc_flag_i = ($urandom_range(0, 9) == 0) ? N'(1 << $urandom_range(0, N-1)) : '0;
      if ($urandom_range(0, 99) == 0) ot_flag_i = ~ot_flag_i;
      clr_i     = ($urandom_range(0, 299) == 0);
      step();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule